// File: doc/BRIEF.md
# Floating-Point Status and Control Register with Exception Priority

This block keeps the status and control word that sits beside a floating-point datapath. The word holds a rounding-mode selector, two trap enables (underflow and inexact), two sticky flags, a three-bit trap-type code and a software-only field that the hardware only stores and returns. The arithmetic units report the exceptions raised by each instruction on separate event lines, together with a completion strobe. On that strobe the block records the single most important exception in the trap-type code, sets the sticky flags, and decides whether the instruction must trap.

One cycle after the strobe, the block pulses a trap request. It also pulses a positive-zero indication when an underflow is masked, which tells the datapath to deliver +0 in place of the tiny result. Software can replace the whole word with a load. The current word can be read at any time on the status output, which is how a store of the register is served.

Top module: `fpsr_unit`

## Requirements
- R1: Reset clears every bit of the status word and holds the trap request and positive-zero outputs low.
- R2: A load copies bits 15..0 of the load data into the word. Bits 31..16 always read as zero and ignore the load data. A load in the same cycle as a completion strobe wins: the events are ignored and no trap is requested.
- R3: On a completion strobe with events present, the trap-type field (bits 2..0) takes exactly one code. The codes are 000 none, 001 underflow, 010 overflow, 011 divide by zero, 100 illegal instruction, 101 invalid operation and 110 inexact. The order from highest to lowest is illegal, invalid, divide by zero, overflow, underflow, inexact.
- R4: A completion strobe with no event clears the trap-type field to 000 and leaves every other bit unchanged.
- R5: Inexact is recorded (code 110, and the inexact flag at bit 6 is set) only when no other event is present. Alongside any other event, the inexact flag is left unchanged.
- R6: An underflow event always sets the underflow flag (bit 4). When underflow is the recorded code, a trap is requested if the underflow enable (bit 3) is 1. If that enable is 0, the positive-zero output pulses instead and no trap is requested.
- R7: When inexact is the recorded code, a trap is requested only if the inexact enable (bit 5) is 1.
- R8: Overflow, divide by zero, invalid operation and illegal instruction always request a trap. A divide-by-zero event flagged as having a zero dividend is recorded as invalid operation (101).
- R9: The underflow and inexact flags are sticky. Only a load of zero into them, or a reset, clears them.
- R10: The rounding mode (bits 8..7: 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity) appears on the rounding-mode output. The rounding mode and the software field (bits 15..9) change only on a load.
- R11: The trap request and positive-zero outputs are registered. Each is a one-cycle pulse in the cycle after the completion strobe, and each is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Replace the status word with load_data_i |
| load_data_i | input | STAT_W | Value to load |
| done_i | input | 1 | Instruction-complete strobe qualifying the event lines |
| unf_i | input | 1 | Underflow event |
| ovf_i | input | 1 | Overflow event |
| dz_i | input | 1 | Divide-by-zero event |
| zdvd_i | input | 1 | Dividend of the divide was zero (qualifies dz_i) |
| inv_i | input | 1 | Invalid-operation event |
| inx_i | input | 1 | Inexact event |
| ill_i | input | 1 | Illegal-instruction event |
| stat_o | output | STAT_W | Current status word (read-back) |
| rmode_o | output | 2 | Rounding-mode selector |
| quit_o | output | 1 | Trap request pulse |
| pos_zero_o | output | 1 | Masked-underflow positive-zero pulse |

## Verification
The bench builds the block with its default widths: a 32-bit word of which the low 16 bits are live. With these widths, random load data with set upper bits shows that bits 31..16 stay zero. Random event combinations are weighted so that overlapping exceptions, zero-dividend divides and every mix of enable bits occur often. This exercises the whole priority order and both masked and unmasked outcomes of underflow and inexact against an independent model.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

    localparam int TT_LSB   = 0;
    localparam int TT_W     = 3;
    localparam int UEN_BIT  = 3;
    localparam int UFL_BIT  = 4;
    localparam int IEN_BIT  = 5;
    localparam int IFL_BIT  = 6;
    localparam int RM_LSB   = 7;
    localparam int RM_W     = 2;
    localparam int SW_LSB   = 9;

    typedef enum logic [TT_W-1:0] {
        TT_NONE = 3'b000,
        TT_UNF  = 3'b001,
        TT_OVF  = 3'b010,
        TT_DZ   = 3'b011,
        TT_ILL  = 3'b100,
        TT_INV  = 3'b101,
        TT_INX  = 3'b110,
        TT_RSV  = 3'b111
    } trap_e;

endpackage

// File: rtl/fpsr_prio.sv
module fpsr_prio
    import fpsr_pkg::*;
(
    input  logic  unf_i,
    input  logic  ovf_i,
    input  logic  dz_i,
    input  logic  zdvd_i,
    input  logic  inv_i,
    input  logic  inx_i,
    input  logic  ill_i,
    output trap_e code_o
);
    logic inv_eff;
    logic dz_eff;

    always_comb begin
        inv_eff = inv_i | (dz_i & zdvd_i);
        dz_eff  = dz_i & ~zdvd_i;
        if (ill_i)        code_o = TT_ILL;
        else if (inv_eff) code_o = TT_INV;
        else if (dz_eff)  code_o = TT_DZ;
        else if (ovf_i)   code_o = TT_OVF;
        else if (unf_i)   code_o = TT_UNF;
        else if (inx_i)   code_o = TT_INX;
        else              code_o = TT_NONE;
    end
endmodule

// File: rtl/fpsr_trap.sv
module fpsr_trap
    import fpsr_pkg::*;
(
    input  trap_e code_i,
    input  logic  uen_i,
    input  logic  ien_i,
    output logic  quit_o,
    output logic  pz_o
);
    always_comb begin
        quit_o = 1'b0;
        pz_o   = 1'b0;
        unique case (code_i)
            TT_OVF, TT_DZ, TT_ILL, TT_INV: quit_o = 1'b1;
            TT_UNF: begin
                quit_o = uen_i;
                pz_o   = ~uen_i;
            end
            TT_INX:  quit_o = ien_i;
            default: quit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
    import fpsr_pkg::*;
#(
    parameter int STAT_W = 32,
    parameter int LIVE_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [STAT_W-1:0] load_data_i,
    input  logic              done_i,
    input  logic              unf_i,
    input  logic              ovf_i,
    input  logic              dz_i,
    input  logic              zdvd_i,
    input  logic              inv_i,
    input  logic              inx_i,
    input  logic              ill_i,
    output logic [STAT_W-1:0] stat_o,
    output logic [RM_W-1:0]   rmode_o,
    output logic              quit_o,
    output logic              pos_zero_o
);
    typedef struct packed {
        logic [LIVE_W-1:0] live;
        logic              quit;
        logic              pz;
    } state_t;

    state_t state_d, state_q;
    trap_e  code;
    logic   trap_req, pz_req;
    logic   unused_hi;

    assign unused_hi = ^load_data_i[STAT_W-1:LIVE_W];

    fpsr_prio prio_i (
        .unf_i  (unf_i),
        .ovf_i  (ovf_i),
        .dz_i   (dz_i),
        .zdvd_i (zdvd_i),
        .inv_i  (inv_i),
        .inx_i  (inx_i),
        .ill_i  (ill_i),
        .code_o (code)
    );

    fpsr_trap trap_i (
        .code_i (code),
        .uen_i  (state_q.live[UEN_BIT]),
        .ien_i  (state_q.live[IEN_BIT]),
        .quit_o (trap_req),
        .pz_o   (pz_req)
    );

    always_comb begin
        state_d      = state_q;
        state_d.quit = 1'b0;
        state_d.pz   = 1'b0;
        if (load_i) begin
            state_d.live = load_data_i[LIVE_W-1:0];
        end else if (done_i) begin
            state_d.live[TT_LSB +: TT_W] = code;
            if (unf_i)
                state_d.live[UFL_BIT] = 1'b1;
            if (code == TT_INX)
                state_d.live[IFL_BIT] = 1'b1;
            state_d.quit = trap_req;
            state_d.pz   = pz_req;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign stat_o     = STAT_W'(state_q.live);
    assign rmode_o    = state_q.live[RM_LSB +: RM_W];
    assign quit_o     = state_q.quit;
    assign pos_zero_o = state_q.pz;
endmodule

// File: rtl/fpsr_unit_chk.sv
module fpsr_unit_chk
    import fpsr_pkg::*;
#(
    parameter int STAT_W = 32,
    parameter int LIVE_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              load_i,
    input logic [STAT_W-1:0] load_data_i,
    input logic              done_i,
    input logic              unf_i,
    input logic              ovf_i,
    input logic              dz_i,
    input logic              zdvd_i,
    input logic              inv_i,
    input logic              inx_i,
    input logic              ill_i,
    input logic [STAT_W-1:0] stat_o,
    input logic [RM_W-1:0]   rmode_o,
    input logic              quit_o,
    input logic              pos_zero_o
);
    logic act, hard, any_ev;
    assign act    = done_i & ~load_i;
    assign hard   = ovf_i | dz_i | inv_i | ill_i;
    assign any_ev = hard | unf_i | inx_i;

    // R2: upper bits never set
    a_r2_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_o[STAT_W-1:LIVE_W] == '0);

    // R4: clean completion clears the trap-type field
    a_r4_clean_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act && !any_ev) |=> (stat_o[TT_LSB +: TT_W] == TT_NONE && !quit_o));

    // R6: masked underflow yields positive zero, no trap
    a_r6_masked_unf: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act && unf_i && !hard && !stat_o[UEN_BIT]) |=> (pos_zero_o && !quit_o));

    // R7: masked inexact alone never traps
    a_r7_masked_inx: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act && inx_i && !hard && !unf_i && !stat_o[IEN_BIT]) |=> !quit_o);

    // R8: hard exceptions always trap
    a_r8_hard_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act && hard) |=> quit_o);

    // R9: sticky flags hold without a load
    a_r9_uf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_o[UFL_BIT] && !load_i) |=> stat_o[UFL_BIT]);
    a_r9_if_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_o[IFL_BIT] && !load_i) |=> stat_o[IFL_BIT]);

    // R10: rounding mode and software field change only on a load
    a_r10_ctrl_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(stat_o[LIVE_W-1:RM_LSB]));

    // R11: no pulse without an accepted completion
    a_r11_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !act |=> (!quit_o && !pos_zero_o));
endmodule

bind fpsr_unit fpsr_unit_chk #(.STAT_W(STAT_W), .LIVE_W(LIVE_W)) chk_i (.*);

// File: tb/fpsr_unit_tb_top.sv
module fpsr_unit_tb_top;
    localparam int STAT_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load = 1'b0;
    logic [STAT_W-1:0] ldata = '0;
    logic              done = 1'b0;
    logic [6:0]        ev = '0; // 0 unf,1 ovf,2 dz,3 zdvd,4 inv,5 inx,6 ill
    logic [STAT_W-1:0] stat;
    logic [1:0]        rmode;
    logic              quit, pz;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_stat = '0;
    logic        m_quit = 1'b0, m_pz = 1'b0;

    always #2 clk = ~clk;

    fpsr_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .load_i(load), .load_data_i(ldata),
        .done_i(done), .unf_i(ev[0]), .ovf_i(ev[1]), .dz_i(ev[2]),
        .zdvd_i(ev[3]), .inv_i(ev[4]), .inx_i(ev[5]), .ill_i(ev[6]),
        .stat_o(stat), .rmode_o(rmode), .quit_o(quit), .pos_zero_o(pz)
    );

    function automatic logic [2:0] exp_code(input logic [6:0] e);
        if (e[6])                return 3'b100;
        if (e[4] || (e[2] && e[3])) return 3'b101;
        if (e[2])                return 3'b011;
        if (e[1])                return 3'b010;
        if (e[0])                return 3'b001;
        if (e[5])                return 3'b110;
        return 3'b000;
    endfunction

    task automatic model_step(input logic l, input logic [31:0] d,
                              input logic dn, input logic [6:0] e);
        logic [2:0] c;
        logic [31:0] s;
        s = m_stat;
        m_quit = 1'b0;
        m_pz = 1'b0;
        if (l) begin
            m_stat = {16'h0, d[15:0]};
        end else if (dn) begin
            c = exp_code(e);
            m_stat[2:0] = c;
            if (e[0]) m_stat[4] = 1'b1;
            if (c == 3'b110) m_stat[6] = 1'b1;
            m_quit = (c == 3'b010) || (c == 3'b011) || (c == 3'b100) ||
                     (c == 3'b101) || (c == 3'b001 && s[3]) ||
                     (c == 3'b110 && s[5]);
            m_pz = (c == 3'b001) && !s[3];
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic step(input string tag, input logic l, input logic [31:0] d,
                        input logic dn, input logic [6:0] e);
        @(negedge clk);
        load = l; ldata = d; done = dn; ev = e;
        @(posedge clk);
        model_step(l, d, dn, e);
        #1;
        load = 1'b0; done = 1'b0; ev = '0;
        chk(tag, stat, m_stat);
        chk(tag, {30'h0, quit, pz}, {30'h0, m_quit, m_pz});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [6:0] e;
        void'($urandom(32'h5eed_f00d));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset word", stat, 32'h0);
        chk("R1 reset pulses", {30'h0, quit, pz}, 32'h0);
        rst_n = 1'b1;

        step("R2 load upper ignored", 1'b1, 32'hFFFF_0181, 1'b0, 7'h0);
        chk("R10 rounding mode out", {30'h0, rmode}, 32'h3);
        step("R4 clean completion", 1'b0, 0, 1'b1, 7'h0);
        step("R3 ill over all", 1'b0, 0, 1'b1, 7'h7F);
        step("R8 zero dividend is invalid", 1'b0, 0, 1'b1, 7'b0001100);
        step("R8 divide by zero", 1'b0, 0, 1'b1, 7'b0000100);
        step("R3 ovf over unf", 1'b0, 0, 1'b1, 7'b0000011);
        step("R5 inexact with other", 1'b0, 0, 1'b1, 7'b0100010);
        step("R6 masked underflow", 1'b0, 0, 1'b1, 7'b0000001);
        step("R7 masked inexact", 1'b0, 0, 1'b1, 7'b0100000);
        step("R11 idle no pulse", 1'b0, 0, 1'b0, 7'h7F);
        step("R9 flags kept", 1'b0, 0, 1'b1, 7'h0);
        step("R2 load enables", 1'b1, 32'h0000_0028, 1'b0, 7'h0);
        step("R6 enabled underflow", 1'b0, 0, 1'b1, 7'b0000001);
        step("R7 enabled inexact", 1'b0, 0, 1'b1, 7'b0100000);
        step("R2 load wins", 1'b1, 32'h0000_FE00, 1'b1, 7'h7F);
        chk("R10 sw field", {16'h0, stat[15:9], 9'h0}, 32'h0000_FE00);

        for (int i = 0; i < 500; i++) begin
            logic l, dn;
            string tag;
            e = 7'($urandom) & 7'($urandom);
            l = ($urandom_range(0, 7) == 0);
            dn = ($urandom_range(0, 3) != 0);
            if (l) tag = "R2 random load";
            else if (!dn) tag = "R11 random idle";
            else if (e == 0 || e == 7'b0001000) tag = "R4 random clean";
            else tag = "R3 random events";
            step(tag, l, $urandom, dn, e);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule